// File: doc/BRIEF.md
# Multi-Distance Rotation Squaring Shifter

This unit rotates a W-bit normal-basis field element to the right by a requested amount k. Since one right rotation of such an element squares it, a rotation by k stands for k successive squarings, which is the long step of addition-chain inversion. Rather than a full barrel shifter (any k in one cycle) or a single one-bit rotator (k cycles), the unit holds a small fixed set of rotation distances behind one multiplexer and covers k as a sum of those distances over several cycles.

The distances and the list of amounts that get a fast schedule are elaboration-time parameters. For every listed amount the schedule is derived at elaboration by taking the largest distance as many times as fits, then the next, down to the one-bit distance. Other amounts are reduced modulo W and done entirely with one-bit steps. A start strobe loads the operand and amount; a done pulse marks the cycle in which `result` holds the final word.

Top module: `sqsh_rotator`

## Requirements
- R1: While reset is held and right after it, `done` is 0 and `result` is all zeros.
- R2: A start accepted while idle captures `operand` and `amount`; when `done` is high, bit i of `result` equals bit (i + k) mod W of the captured operand, with k = `amount` mod W.
- R3: A listed amount takes as many steps as its largest-first decomposition into the distance set; with the defaults (distances 81, 20, 5, 1) amounts 1, 2, 5, 10, 20, 40, 81 take 1, 2, 1, 2, 1, 2, 1 steps.
- R4: An amount not in the list takes (`amount` mod W) one-bit steps, so 244 takes 81 steps although 81 is listed.
- R5: An amount that is 0 modulo W takes zero steps and returns the operand unchanged.
- R6: With start sampled on edge E0 and N steps needed, `done` is high exactly in the cycle after edge E_N and low in every other cycle of that operation.
- R7: A start seen while an operation is in progress is ignored; the running operation's result and finish cycle are unchanged.
- R8: While idle with no start, `result` keeps its value and `done` stays low.
- R9: A start may be accepted in the very cycle `done` is high, giving back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| amount | input | AW ($clog2(W)+1) | Requested rotation amount k |
| operand | input | W | Element to rotate |
| result | output | W | Rotated element; final when `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives every listed amount, several unlisted ones including values at and beyond W, and zero; a wrong schedule shows up as `done` in the wrong cycle, and a wrong direction or modulus as a mismatched word. The case 244 catches a design that reduces modulo W before the list lookup and so takes the fast path. A start issued mid-operation catches a design that reloads, which would change both the word and the finish cycle, and a start on the `done` cycle catches a design that needs an extra idle cycle between operations.

// File: rtl/sqsh_pkg.sv
package sqsh_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sqsh_plan.sv
module sqsh_plan #(
    parameter int W        = 163,
    parameter int NR       = 4,
    parameter int ROTS [NR] = '{81, 20, 5, 1},
    parameter int NK       = 7,
    parameter int AMTS [NK] = '{1, 2, 5, 10, 20, 40, 81},
    localparam int CW      = $clog2(W),
    localparam int AW      = $clog2(W) + 1
) (
    input  logic [AW-1:0]          amount,
    output logic [NR-1:0][CW-1:0]  counts
);

    // Largest-first split of amt: how often distance index j is used.
    function automatic int split_cnt(input int amt, input int j);
        int rem;
        int c;
        rem = amt;
        for (int t = 0; t < NR; t++) begin
            c = rem / ROTS[t];
            if (t == j) return c;
            rem = rem - c * ROTS[t];
        end
        return 0;
    endfunction

    logic [NR-1:0][CW-1:0] row [NK];

    for (genvar i = 0; i < NK; i++) begin : g_amt
        for (genvar j = 0; j < NR; j++) begin : g_rot
            localparam int C = split_cnt(AMTS[i], j);
            assign row[i][j] = CW'(C);
        end
    end

    always_comb begin
        logic hit;
        hit    = 1'b0;
        counts = '0;
        for (int i = 0; i < NK; i++) begin
            if (!hit && amount == AW'(AMTS[i])) begin
                hit    = 1'b1;
                counts = row[i];
            end
        end
        if (!hit) begin
            counts[NR-1] = CW'(amount % AW'(W));
        end
    end

endmodule

// File: rtl/sqsh_rotmux.sv
module sqsh_rotmux #(
    parameter int W        = 163,
    parameter int NR       = 4,
    parameter int ROTS [NR] = '{81, 20, 5, 1},
    localparam int SW      = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  dout
);

    logic [NR-1:0][W-1:0] cand;

    for (genvar j = 0; j < NR; j++) begin : g_dist
        assign cand[j] = {din[ROTS[j]-1:0], din[W-1:ROTS[j]]};
    end

    always_comb begin
        dout = cand[0];
        for (int j = 0; j < NR; j++) begin
            if (sel == SW'(j)) dout = cand[j];
        end
    end

endmodule

// File: rtl/sqsh_rotator.sv
module sqsh_rotator #(
    parameter int W        = 163,
    parameter int NR       = 4,
    parameter int ROTS [NR] = '{81, 20, 5, 1},
    parameter int NK       = 7,
    parameter int AMTS [NK] = '{1, 2, 5, 10, 20, 40, 81},
    localparam int CW      = $clog2(W),
    localparam int AW      = $clog2(W) + 1,
    localparam int SW      = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] amount,
    input  logic [W-1:0]  operand,
    output logic [W-1:0]  result,
    output logic          done
);
    import sqsh_pkg::*;

    typedef struct packed {
        phase_e                phase;
        logic                  done;
        logic [W-1:0]          data;
        logic [NR-1:0][CW-1:0] cnt;
    } state_t;

    state_t                st_d, st_q;
    logic [NR-1:0][CW-1:0] plan_cnt;
    logic [SW-1:0]         sel;
    logic [W-1:0]          rot_out;
    logic                  busy_w;
    logic                  plan_zero;
    logic                  last_step;

    sqsh_plan #(.W(W), .NR(NR), .ROTS(ROTS), .NK(NK), .AMTS(AMTS)) u_plan (
        .amount (amount),
        .counts (plan_cnt)
    );

    sqsh_rotmux #(.W(W), .NR(NR), .ROTS(ROTS)) u_mux (
        .din  (st_q.data),
        .sel  (sel),
        .dout (rot_out)
    );

    assign busy_w = (st_q.phase == PH_RUN);

    // Largest remaining distance first: lowest index with steps left.
    always_comb begin
        sel       = '0;
        plan_zero = 1'b1;
        last_step = 1'b1;
        for (int j = NR - 1; j >= 0; j--) begin
            if (st_q.cnt[j] != '0) sel = SW'(j);
        end
        for (int j = 0; j < NR; j++) begin
            if (plan_cnt[j] != '0) plan_zero = 1'b0;
            if (SW'(j) != sel && st_q.cnt[j] != '0) last_step = 1'b0;
        end
        if (st_q.cnt[sel] > CW'(1)) last_step = 1'b0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!busy_w) begin
            if (start) begin
                st_d.data = operand;
                st_d.cnt  = plan_cnt;
                if (plan_zero) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.phase = PH_RUN;
                end
            end
        end else begin
            st_d.data     = rot_out;
            st_d.cnt[sel] = st_q.cnt[sel] - CW'(1);
            if (last_step) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, data: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.data;
    assign done   = st_q.done;

endmodule

// File: rtl/sqsh_rotator_chk.sv
module sqsh_rotator_chk #(
    parameter int W = 163
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && !done));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy || done));

    // R3
    finish_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && $past(busy)) |=> (busy || done));

endmodule

bind sqsh_rotator sqsh_rotator_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy_w),
    .done   (done),
    .result (result)
);

// File: tb/test_sqsh_rotator.sv
module test_sqsh_rotator;
    localparam int W  = 163;
    localparam int AW = $clog2(W) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] amount = '0;
    logic [W-1:0]  operand = '0;
    logic [W-1:0]  result;
    logic          done;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string cur_tag = "R2";

    // reference model state
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         m_left = 0;
    logic [W-1:0] m_res = '0;

    always #5 clk = ~clk;

    sqsh_rotator i_sqsh_rotator (
        .clk(clk), .rst_n(rst_n), .start(start), .amount(amount),
        .operand(operand), .result(result), .done(done)
    );

    function automatic logic [W-1:0] ref_rot(input logic [W-1:0] x, input int k);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = x[(i + k) % W];
        return r;
    endfunction

    // step counts from R3 / R4 / R5
    function automatic int ref_steps(input int a);
        case (a)
            1, 5, 20, 81: return 1;
            2, 10, 40:    return 2;
            default:      return a % W;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_left = 0; m_res = '0;
        end else begin
            m_done = 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_res  = ref_rot(operand, int'(amount) % W);
                    m_left = ref_steps(int'(amount));
                    if (m_left == 0) m_done = 1'b1;
                    else m_busy = 1'b1;
                end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL %s/R6 done: actual=%0b expected=%0b", cur_tag, done, m_done);
            end
            if (!m_busy) begin
                checks++;
                if (result !== m_res) begin
                    errors++;
                    $display("FAIL %s result: actual=%h expected=%h",
                             m_done ? cur_tag : "R8", result, m_res);
                end
            end
        end
    end

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        for (int i = 0; i < W; i += 32) v = {v[W-33:0], $urandom()};
        return v;
    endfunction

    // Starts at the current negedge; returns at the negedge where done is expected.
    task automatic run_op(input int k, input logic [W-1:0] x, input string tag,
                          input bit poke_busy);
        cur_tag = tag;
        start = 1'b1; amount = AW'(k); operand = x;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            start = 1'b1; amount = AW'(1); operand = ~x;   // R7: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (!m_done) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 during reset
        if (done !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual done=%0b result=%h expected 0/0", done, result);
        end
        rst_n = 1'b1;
        idle(2);
        checks++;   // R1 after release
        if (done !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 after reset: actual done=%0b result=%h expected 0/0", done, result);
        end
        begin
            int listed [7] = '{1, 2, 5, 10, 20, 40, 81};
            foreach (listed[i]) begin
                run_op(listed[i], rnd_word(), "R3", 1'b0);   // R2 word, R3 timing
                idle(2);
            end
        end
        run_op(3,   rnd_word(), "R4", 1'b0); idle(2);
        run_op(162, rnd_word(), "R4", 1'b0); idle(2);
        run_op(164, rnd_word(), "R4", 1'b0); idle(2);
        run_op(244, rnd_word(), "R4", 1'b0); idle(2);
        run_op(511, rnd_word(), "R4", 1'b0); idle(2);
        run_op(0,   rnd_word(), "R5", 1'b0); idle(2);
        run_op(163, rnd_word(), "R5", 1'b0); idle(2);
        run_op(326, rnd_word(), "R5", 1'b0); idle(2);
        run_op(50,  rnd_word(), "R7", 1'b1); idle(2);
        run_op(40,  rnd_word(), "R7", 1'b1); idle(3);
        // R9: back-to-back starts on the done cycle
        run_op(10,  rnd_word(), "R9", 1'b0);
        run_op(0,   rnd_word(), "R9", 1'b0);
        run_op(7,   rnd_word(), "R9", 1'b0);
        run_op(81,  rnd_word(), "R9", 1'b0);
        idle(5);    // R8 hold window
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule